// File: doc/BRIEF.md
# Low-Power Wakeup Sequencer

This block takes a processor core out of its two low-power states. While the core runs, a mode request moves the block into a light-sleep state, where instruction execution pauses, or into a deep-sleep state, where the core's oscillator-based logic waits. In either state the core clock enable is held low until a wake condition has been accepted.

A wake condition is any enabled interrupt line, the watchdog interrupt, or the non-maskable interrupt. In light sleep, the wake signal must stay high for a minimum width. That width depends on whether input qualification is on. After the wake is accepted, the block keeps counting from the first high sample until a resume latency has passed. The latency depends on the memory the next instruction comes from. A single-cycle resume strobe then fires and the core clock comes back. In deep sleep, the wake signal must stay high for a programmable number of oscillator cycles, and the strobe fires as soon as that count is reached. In this state the block clock is the oscillator clock. An external reset request overrides both states at once, with no qualification.

The `rst_n` input is expected to be released synchronously upstream.

Top module: `wakeup_seq`

## Requirements
- R1: After reset the core clock enable is 1 and the resume strobe is 0.
- R2: In the run state, a mode request of 2'b01 (light sleep) or 2'b10 (deep sleep) at a clock edge drops the core clock enable from the next cycle. A request of 2'b00 or 2'b11 has no effect. A request is not taken while the external reset request is high.
- R3: The wake signal is the OR of the watchdog interrupt, the non-maskable interrupt and each interrupt line ANDed with its enable bit. A line whose enable bit is 0 does not wake the block.
- R4: In light sleep with qualification off, a wake held for 2 consecutive samples is accepted. A 1-sample pulse is ignored.
- R5: In light sleep with qualification on, acceptance needs 5 + W consecutive samples, where W is the qualification window input.
- R6: With fetch from on-chip RAM, or from flash that is awake, and qualification off, the resume strobe is high in the cycle after the 20th edge, counting the first edge that samples the wake high as the 1st.
- R7: With fetch from flash that is asleep, that edge count is 1050.
- R8: With qualification on, W is added to the light-sleep resume count.
- R9: In deep sleep, the strobe is high in the cycle after the edge that makes the count of consecutive wake samples reach the required width. That width is 2 + N with qualification on, where N is the 6-bit deep-sleep field, and 3 with qualification off.
- R10: If the wake drops before the required width is reached, the count restarts from zero and the block stays asleep. Once the wake is accepted in light sleep, it may drop without effect.
- R11: The resume strobe lasts exactly one cycle. In that cycle the core clock enable is already 1.
- R12: In either sleep state the external reset request raises the core clock enable combinationally. It returns the block to run at the next edge with no resume strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (system clock; oscillator clock in deep sleep) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpm_req | input | 2 | Mode request: 01 light sleep, 10 deep sleep |
| irq_line | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line wake enables |
| wdog_irq | input | 1 | Watchdog interrupt |
| nmi_irq | input | 1 | Non-maskable interrupt |
| ext_rst | input | 1 | External reset request, asynchronous override |
| qual_en | input | 1 | Input qualification enable |
| qual_win | input | QW_W | Qualification window width W in cycles |
| stby_n | input | 6 | Deep-sleep qualification field N |
| flash_fetch | input | 1 | Next instruction is fetched from flash |
| flash_sleep | input | 1 | Flash is in its sleep state |
| core_clk_en | output | 1 | Core clock enable |
| resume_stb | output | 1 | One-cycle resume strobe |

## Verification
A wrong state or count in this block shows up only as the clock enable or the strobe moving at the wrong edge. An off-by-one in a width threshold or a latency moves the strobe by one cycle, and a pulse exactly at the limit would be accepted or refused wrongly. For this reason, pulses one sample short of and exactly at each width are applied, and the outputs are compared on every cycle against a behavioural model. An error is then seen within the same cycle it reaches the ports. A lost restart of the count shows up as a strobe after a pulse that should have been ignored.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    WK_RUN  = 2'd0,
    WK_IDLE = 2'd1,
    WK_STBY = 2'd2
  } wk_state_e;

  localparam logic [1:0] LPM_IDLE = 2'b01;
  localparam logic [1:0] LPM_STBY = 2'b10;
endpackage

// File: rtl/wk_wake_merge.sv
module wk_wake_merge #(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0] irq_line,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            wdog_irq,
  input  logic            nmi_irq,
  output logic            wake
);
  logic [NIRQ-1:0] gated;

  for (genvar i = 0; i < NIRQ; i++) begin : g_gate
    assign gated[i] = irq_line[i] & irq_en[i];
  end

  assign wake = (|gated) | wdog_irq | nmi_irq;
endmodule

// File: rtl/wk_limits.sv
module wk_limits #(
  parameter int QW_W      = 4,
  parameter int NQ_W      = 6,
  parameter int CNT_W     = 11,
  parameter int FAST_DLY  = 20,
  parameter int SLOW_DLY  = 1050,
  parameter int IDLE_RAW  = 2,
  parameter int IDLE_QUAL = 5,
  parameter int STBY_RAW  = 3,
  parameter int STBY_QUAL = 2
) (
  input  logic             qual_en,
  input  logic [QW_W-1:0]  qual_win,
  input  logic [NQ_W-1:0]  stby_n,
  input  logic             flash_fetch,
  input  logic             flash_sleep,
  output logic [CNT_W-1:0] idle_need,
  output logic [CNT_W-1:0] idle_delay,
  output logic [CNT_W-1:0] stby_need
);
  logic [CNT_W-1:0] win_add;
  logic [CNT_W-1:0] base_dly;

  always_comb begin
    win_add  = qual_en ? CNT_W'(qual_win) : '0;
    base_dly = (flash_fetch && flash_sleep) ? CNT_W'(SLOW_DLY) : CNT_W'(FAST_DLY);
    idle_need  = qual_en ? (CNT_W'(IDLE_QUAL) + win_add) : CNT_W'(IDLE_RAW);
    idle_delay = base_dly + win_add;
    stby_need  = qual_en ? (CNT_W'(STBY_QUAL) + CNT_W'(stby_n)) : CNT_W'(STBY_RAW);
  end
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lpm_req,
  input  logic             wake,
  input  logic             ext_rst,
  input  logic [CNT_W-1:0] idle_need,
  input  logic [CNT_W-1:0] idle_delay,
  input  logic [CNT_W-1:0] stby_need,
  output wk_state_e        st,
  output logic             stb
);
  wk_state_e        st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [CNT_W-1:0] cnt_inc;
  logic             stb_nx;

  assign cnt_inc = cnt + CNT_W'(1);

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    stb_nx = 1'b0;
    unique case (st)
      WK_IDLE: begin
        if (ext_rst) begin
          st_nx  = WK_RUN;
          cnt_nx = '0;
        end else if (wake || cnt >= idle_need) begin
          if (cnt_inc == idle_delay) begin
            st_nx  = WK_RUN;
            stb_nx = 1'b1;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_inc;
          end
        end else begin
          cnt_nx = '0;
        end
      end
      WK_STBY: begin
        if (ext_rst) begin
          st_nx  = WK_RUN;
          cnt_nx = '0;
        end else if (wake) begin
          if (cnt_inc == stby_need) begin
            st_nx  = WK_RUN;
            stb_nx = 1'b1;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_inc;
          end
        end else begin
          cnt_nx = '0;
        end
      end
      default: begin
        cnt_nx = '0;
        if (!ext_rst) begin
          if (lpm_req == LPM_IDLE)      st_nx = WK_IDLE;
          else if (lpm_req == LPM_STBY) st_nx = WK_STBY;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= WK_RUN;
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      stb <= stb_nx;
    end
  end
endmodule

// File: rtl/wakeup_seq.sv
module wakeup_seq
  import wk_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter int QW_W     = 4,
  parameter int FAST_DLY = 20,
  parameter int SLOW_DLY = 1050
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      lpm_req,
  input  logic [NIRQ-1:0] irq_line,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            wdog_irq,
  input  logic            nmi_irq,
  input  logic            ext_rst,
  input  logic            qual_en,
  input  logic [QW_W-1:0] qual_win,
  input  logic [5:0]      stby_n,
  input  logic            flash_fetch,
  input  logic            flash_sleep,
  output logic            core_clk_en,
  output logic            resume_stb
);
  localparam int NQ_W    = 6;
  localparam int MAX_CNT = SLOW_DLY + (1 << QW_W);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             wake;
  logic [CNT_W-1:0] idle_need, idle_delay, stby_need;
  wk_state_e        st;
  logic             stb;

  wk_wake_merge #(.NIRQ(NIRQ)) u_merge (
    .irq_line (irq_line),
    .irq_en   (irq_en),
    .wdog_irq (wdog_irq),
    .nmi_irq  (nmi_irq),
    .wake     (wake)
  );

  wk_limits #(
    .QW_W(QW_W), .NQ_W(NQ_W), .CNT_W(CNT_W),
    .FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)
  ) u_limits (
    .qual_en     (qual_en),
    .qual_win    (qual_win),
    .stby_n      (stby_n),
    .flash_fetch (flash_fetch),
    .flash_sleep (flash_sleep),
    .idle_need   (idle_need),
    .idle_delay  (idle_delay),
    .stby_need   (stby_need)
  );

  wk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpm_req    (lpm_req),
    .wake       (wake),
    .ext_rst    (ext_rst),
    .idle_need  (idle_need),
    .idle_delay (idle_delay),
    .stby_need  (stby_need),
    .st         (st),
    .stb        (stb)
  );

  assign core_clk_en = (st == WK_RUN) | ext_rst;
  assign resume_stb  = stb;
endmodule

// File: rtl/wakeup_seq_chk.sv
module wakeup_seq_chk
  import wk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lpm_req,
  input logic       ext_rst,
  input logic       core_clk_en,
  input logic       resume_stb,
  input wk_state_e  st
);
  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |=> !resume_stb);

  p_stb_clk_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |-> core_clk_en);

  p_override_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |-> core_clk_en);

  p_override_nostb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != WK_RUN && ext_rst) |=> (st == WK_RUN && !resume_stb));

  p_enter_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WK_RUN && !ext_rst && lpm_req == LPM_IDLE) |=> st == WK_IDLE);

  p_enter_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WK_RUN && !ext_rst && lpm_req == LPM_STBY) |=> st == WK_STBY);

  p_stb_from_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_stb) |-> $past(st) != WK_RUN);
endmodule

bind wakeup_seq wakeup_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lpm_req     (lpm_req),
  .ext_rst     (ext_rst),
  .core_clk_en (core_clk_en),
  .resume_stb  (resume_stb),
  .st          (st)
);

// File: tb/wakeup_seq_bench.sv
module wakeup_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lpm_req = 2'b00;
  logic [7:0] irq_line = '0, irq_en = '0;
  logic       wdog_irq = 1'b0, nmi_irq = 1'b0, ext_rst = 1'b0;
  logic       qual_en = 1'b0;
  logic [3:0] qual_win = '0;
  logic [5:0] stby_n = '0;
  logic       flash_fetch = 1'b0, flash_sleep = 1'b0;
  logic       core_clk_en, resume_stb;

  int checks = 0, errors = 0, cycles = 0, stb_seen = 0;
  string tag = "R1";

  // reference model state
  int m_mode = 0, m_cnt = 0;
  bit m_stb = 0;

  always #2.5 clk = ~clk;

  wakeup_seq u_wakeup_seq (
    .clk(clk), .rst_n(rst_n), .lpm_req(lpm_req), .irq_line(irq_line),
    .irq_en(irq_en), .wdog_irq(wdog_irq), .nmi_irq(nmi_irq), .ext_rst(ext_rst),
    .qual_en(qual_en), .qual_win(qual_win), .stby_n(stby_n),
    .flash_fetch(flash_fetch), .flash_sleep(flash_sleep),
    .core_clk_en(core_clk_en), .resume_stb(resume_stb)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_stb = 0;
    end else begin
      bit wk;
      int need, dly;
      wk = (|(irq_line & irq_en)) | wdog_irq | nmi_irq;
      m_stb = 0;
      if (m_mode == 0) begin
        m_cnt = 0;
        if (!ext_rst && lpm_req == 2'b01) m_mode = 1;
        else if (!ext_rst && lpm_req == 2'b10) m_mode = 2;
      end else if (ext_rst) begin
        m_mode = 0; m_cnt = 0;
      end else if (m_mode == 1) begin
        need = qual_en ? 5 + int'(qual_win) : 2;
        dly  = ((flash_fetch && flash_sleep) ? 1050 : 20) + (qual_en ? int'(qual_win) : 0);
        if (wk || m_cnt >= need) begin
          if (m_cnt + 1 == dly) begin m_mode = 0; m_stb = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end else begin
        need = qual_en ? 2 + int'(stby_n) : 3;
        if (wk) begin
          if (m_cnt + 1 == need) begin m_mode = 0; m_stb = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", t, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({tag, " clk_en"}, int'(core_clk_en), int'(m_mode == 0 || ext_rst));
      check({tag, " strobe"}, int'(resume_stb), int'(m_stb));
      if (resume_stb) stb_seen++;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enter(input logic [1:0] code);
    @(posedge clk); #1 lpm_req = code;
    @(posedge clk); #1 lpm_req = 2'b00;
  endtask

  // kind 0 watchdog, 1 nmi, 2 enabled line 5, 3 disabled line 3
  task automatic pulse(input int kind, input int n);
    @(posedge clk); #1;
    case (kind)
      0: wdog_irq = 1'b1;
      1: nmi_irq = 1'b1;
      2: irq_line[5] = 1'b1;
      default: irq_line[3] = 1'b1;
    endcase
    step(n);
    wdog_irq = 1'b0; nmi_irq = 1'b0; irq_line = '0;
  endtask

  initial begin
    int s0;
    irq_en = 8'b0010_0000;
    step(3);
    tag = "R1";
    check("R1 clk_en after reset", int'(core_clk_en), 1);
    check("R1 strobe after reset", int'(resume_stb), 0);
    rst_n = 1'b1;
    step(2);

    tag = "R2";
    @(posedge clk); #1 lpm_req = 2'b11; step(3); lpm_req = 2'b00;
    check("R2 code 11 ignored", int'(core_clk_en), 1);
    enter(2'b01);
    check("R2 light sleep entered", int'(core_clk_en), 0);

    tag = "R4";
    s0 = stb_seen;
    pulse(0, 1); step(30);
    check("R4 one-sample pulse ignored", stb_seen - s0, 0);
    tag = "R6";
    pulse(0, 2); step(25);
    check("R6 resume after 2-sample pulse", stb_seen - s0, 1);
    check("R11 clock back on", int'(core_clk_en), 1);

    tag = "R3";
    enter(2'b01);
    s0 = stb_seen;
    pulse(3, 6); step(25);
    check("R3 disabled line ignored", stb_seen - s0, 0);
    pulse(1, 2); step(25);
    check("R3 nmi wakes", stb_seen - s0, 1);
    enter(2'b01);
    pulse(2, 2); step(25);
    check("R3 enabled line wakes", stb_seen - s0, 2);

    tag = "R7";
    flash_fetch = 1'b1; flash_sleep = 1'b1;
    enter(2'b01);
    s0 = stb_seen;
    pulse(0, 2); step(1040);
    check("R7 no strobe before 1050", stb_seen - s0, 0);
    step(20);
    check("R7 strobe after 1050", stb_seen - s0, 1);
    flash_sleep = 1'b0;

    tag = "R5";
    qual_en = 1'b1; qual_win = 4'd3;
    enter(2'b01);
    s0 = stb_seen;
    pulse(0, 7); step(40);
    check("R10 short qualified pulse restarts", stb_seen - s0, 0);
    tag = "R8";
    pulse(0, 8); step(30);
    check("R8 qualified resume", stb_seen - s0, 1);

    tag = "R9";
    qual_en = 1'b0;
    enter(2'b10);
    s0 = stb_seen;
    pulse(1, 2); step(5);
    check("R9 deep sleep 2 samples refused", stb_seen - s0, 0);
    pulse(1, 3); step(5);
    check("R9 deep sleep 3 samples accepted", stb_seen - s0, 1);
    qual_en = 1'b1; stby_n = 6'd10;
    enter(2'b10);
    pulse(0, 11); step(5);
    check("R10 deep sleep short pulse", stb_seen - s0, 1);
    pulse(0, 12); step(5);
    check("R9 deep sleep 2+N accepted", stb_seen - s0, 2);
    stby_n = 6'd63;
    enter(2'b10);
    pulse(0, 65); step(5);
    check("R9 deep sleep N=63", stb_seen - s0, 3);

    tag = "R12";
    qual_en = 1'b0;
    enter(2'b01);
    s0 = stb_seen;
    pulse(0, 2); step(5);
    ext_rst = 1'b1; #0.5;
    check("R12 override raises clk_en", int'(core_clk_en), 1);
    step(1); ext_rst = 1'b0; step(30);
    check("R12 no strobe after override", stb_seen - s0, 0);
    check("R12 back in run", int'(core_clk_en), 1);
    enter(2'b10);
    pulse(0, 1);
    ext_rst = 1'b1; step(1); ext_rst = 1'b0; step(5);
    check("R12 deep sleep override", int'(core_clk_en), 1);
    check("R12 deep sleep no strobe", stb_seen - s0, 0);

    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule